// File: doc/BRIEF.md
# Pipelined Three-Tap FIR Filter

This block is a three-tap finite impulse response filter for a sample stream that arrives at one signed sample per clock. Each output is the weighted sum of the newest sample and the two samples before it, with the three weights fixed by parameters. Every multiplier and every adder has its own output register. The clock period therefore only has to cover a single arithmetic element plus register setup and clock-to-output time.

The adder tree first adds the two older product terms, which are ready one clock earlier. The newest product joins in the last adder. With this order a sample that enters at one rising edge produces its filtered result on the output after the next rising edge. That latency of two clocks is the smallest a causal filter can have when each element is registered. A valid flag moves through a matching two-stage pipeline. In a cycle where the input flag is low, a zero sample enters the taps, so the sample spacing stays uniform. Products and sums keep full precision, so no input or weight can overflow.

Top module: `fir3_pipe`

## Requirements
- R1: In every cycle after reset, `out_data` equals COEF0·x(k) + COEF1·x(k−1) + COEF2·x(k−2) as an exact signed integer. Here x(k) is the sample taken at the rising edge two edges before the output is observed, and x(k−1) and x(k−2) are the samples taken at the two edges before that.
- R2: `out_valid` shows the `in_valid` value taken two rising edges earlier. A sample taken at edge k is marked valid on the output after edge k+1.
- R3: The output is `DATA_W+COEF_W+2` bits of two's complement. With the largest-magnitude inputs (−2^(DATA_W−1) and 2^(DATA_W−1)−1) and any weights, the result is exact and never wraps.
- R4: The filter accepts a new sample on every clock and produces one result on every clock, with no stall cycles between back-to-back valid samples.
- R5: In a cycle where `in_valid` is low, `in_data` is ignored and a zero sample enters the tap history. After three such cycles in a row, `out_data` is zero.
- R6: The active-low reset `rst_n` clears all pipeline state. During reset and on the first two edges after it, `out_valid` is 0 and `out_data` is 0. The first results after reset treat the samples from before reset as zero.
- R7: The weights apply in tap order. A single valid sample of value 1 with zeros around it produces COEF0, COEF1, COEF2 on three consecutive outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The sample on `in_data` is valid this cycle |
| in_data | input | DATA_W | Signed input sample, two's complement |
| out_valid | output | 1 | `out_data` holds the result of a valid sample |
| out_data | output | DATA_W+COEF_W+2 | Signed filter result, full precision |

## Verification
Two things can happen in the same cycle. A new valid sample can enter the product registers while zero samples from an invalid gap are still in the older taps and the adder stages. The first result after a gap is then a mix of real and zero-stuffed terms. The bench provokes this with gaps of one, two and three cycles placed between dense runs of pseudo-random samples, and also with a reset applied in the middle of a stream. A behavioural model keeps a sample history and a queue of expected results. On every clock it compares both the valid flag and the full-precision value, so a wrong value at a gap edge or at a reset edge shows up in the exact cycle where it occurs.

// File: rtl/fir3_pkg.sv
package fir3_pkg;
    localparam int FIR3_TAPS    = 3;
    localparam int FIR3_LATENCY = 2;
    localparam int FIR3_GUARD   = 2;
    localparam int FIR3_DATA_W  = 8;
    localparam int FIR3_COEF_W  = 8;
endpackage

// File: rtl/fir3_tap_line.sv
module fir3_tap_line #(
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic signed [DATA_W-1:0] x_cur,
    output logic signed [DATA_W-1:0] x_prev
);
    typedef struct packed {
        logic signed [DATA_W-1:0] prev;
    } tap_state_t;

    tap_state_t st_d, st_q;
    logic signed [DATA_W-1:0] gated;

    always_comb begin
        gated   = in_valid ? in_data : '0;
        st_d    = st_q;
        st_d.prev = gated;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign x_cur  = gated;
    assign x_prev = st_q.prev;
endmodule

// File: rtl/fir3_mul_bank.sv
module fir3_mul_bank #(
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int COEF0  = 1,
    parameter int COEF1  = 1,
    parameter int COEF2  = 1,
    localparam int PROD_W = DATA_W + COEF_W,
    localparam int TAPS   = fir3_pkg::FIR3_TAPS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DATA_W-1:0] x_cur,
    input  logic signed [DATA_W-1:0] x_prev,
    output logic signed [PROD_W-1:0] prod [TAPS]
);
    localparam logic signed [COEF_W-1:0] WEIGHT [TAPS] = '{
        COEF0[COEF_W-1:0], COEF1[COEF_W-1:0], COEF2[COEF_W-1:0]
    };

    typedef struct packed {
        logic signed [TAPS-1:0][PROD_W-1:0] p;
    } mul_state_t;

    mul_state_t st_d, st_q;
    logic signed [DATA_W-1:0] operand [TAPS];

    // The oldest weight reads the one-sample history; the two newer
    // weights read the current sample, one clock ahead of their use.
    for (genvar i = 0; i < TAPS; i++) begin : g_src
        if (i == TAPS - 1) begin : g_old
            assign operand[i] = x_prev;
        end else begin : g_new
            assign operand[i] = x_cur;
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < TAPS; i++) begin
            st_d.p[i] = PROD_W'(operand[i]) * PROD_W'(WEIGHT[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < TAPS; i++) begin : g_out
        assign prod[i] = $signed(st_q.p[i]);
    end
endmodule

// File: rtl/fir3_add_tree.sv
module fir3_add_tree #(
    parameter int PROD_W = 16,
    parameter int SUM_W  = 18,
    localparam int TAPS  = fir3_pkg::FIR3_TAPS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [PROD_W-1:0] prod [TAPS],
    output logic signed [SUM_W-1:0]  sum
);
    typedef struct packed {
        logic signed [SUM_W-1:0] older;
        logic signed [SUM_W-1:0] total;
    } add_state_t;

    add_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.older = SUM_W'(prod[1]) + SUM_W'(prod[2]);
        st_d.total = SUM_W'(prod[0]) + st_q.older;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum = st_q.total;
endmodule

// File: rtl/fir3_valid_pipe.sv
module fir3_valid_pipe #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vin,
    output logic vout
);
    typedef struct packed {
        logic [DEPTH-1:0] stage;
    } vld_state_t;

    vld_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = vin;
        for (int i = 1; i < DEPTH; i++) begin
            st_d.stage[i] = st_q.stage[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vout = st_q.stage[DEPTH-1];
endmodule

// File: rtl/fir3_pipe.sv
module fir3_pipe #(
    parameter int DATA_W = fir3_pkg::FIR3_DATA_W,
    parameter int COEF_W = fir3_pkg::FIR3_COEF_W,
    parameter int COEF0  = -128,
    parameter int COEF1  = 127,
    parameter int COEF2  = -77,
    localparam int PROD_W = DATA_W + COEF_W,
    localparam int SUM_W  = PROD_W + fir3_pkg::FIR3_GUARD
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [SUM_W-1:0]  out_data
);
    localparam int TAPS = fir3_pkg::FIR3_TAPS;

    logic signed [DATA_W-1:0] x_cur;
    logic signed [DATA_W-1:0] x_prev;
    logic signed [PROD_W-1:0] prod [TAPS];

    fir3_tap_line #(.DATA_W(DATA_W)) u_taps (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .x_cur    (x_cur),
        .x_prev   (x_prev)
    );

    fir3_mul_bank #(
        .DATA_W(DATA_W), .COEF_W(COEF_W),
        .COEF0(COEF0), .COEF1(COEF1), .COEF2(COEF2)
    ) u_mul (
        .clk    (clk),
        .rst_n  (rst_n),
        .x_cur  (x_cur),
        .x_prev (x_prev),
        .prod   (prod)
    );

    fir3_add_tree #(.PROD_W(PROD_W), .SUM_W(SUM_W)) u_add (
        .clk   (clk),
        .rst_n (rst_n),
        .prod  (prod),
        .sum   (out_data)
    );

    fir3_valid_pipe #(.DEPTH(fir3_pkg::FIR3_LATENCY)) u_vld (
        .clk   (clk),
        .rst_n (rst_n),
        .vin   (in_valid),
        .vout  (out_valid)
    );
endmodule

// File: rtl/fir3_pipe_chk.sv
module fir3_pipe_chk #(
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int COEF0  = 1,
    parameter int COEF1  = 1,
    parameter int COEF2  = 1,
    localparam int SUM_W = DATA_W + COEF_W + 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_data,
    input logic                     out_valid,
    input logic signed [SUM_W-1:0]  out_data
);
    localparam logic signed [SUM_W-1:0] W0 = SUM_W'(COEF0);
    localparam logic signed [SUM_W-1:0] W1 = SUM_W'(COEF1);
    localparam logic signed [SUM_W-1:0] W2 = SUM_W'(COEF2);

    logic [2:0] since_rst;
    logic signed [SUM_W-1:0] smp;

    assign smp = in_valid ? SUM_W'(in_data) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    assert_valid_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd2) |-> (out_valid == $past(in_valid, 2)));

    assert_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4) |->
        (out_data == W0 * $past(smp, 2) + W1 * $past(smp, 3) + W2 * $past(smp, 4)));

    assert_reset_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < 3'd2) |-> (!out_valid && out_data == '0));

    assert_gap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst >= 3'd4) && !$past(in_valid, 2) && !$past(in_valid, 3)
         && !$past(in_valid, 4)) |-> (out_data == '0));
endmodule

bind fir3_pipe fir3_pipe_chk #(
    .DATA_W(DATA_W), .COEF_W(COEF_W),
    .COEF0(COEF0), .COEF1(COEF1), .COEF2(COEF2)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/fir3_pipe_tb_top.sv
module fir3_pipe_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 8;
    localparam int COEF_W = 8;
    localparam int SUM_W  = DATA_W + COEF_W + 2;
    localparam int C0 = -128;
    localparam int C1 = 127;
    localparam int C2 = -77;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DATA_W-1:0] in_data = '0;
    logic out_valid;
    logic signed [SUM_W-1:0] out_data;

    int n_checks = 0;
    int n_fail = 0;
    int h1 = 0;
    int h2 = 0;
    int exp_val [$];
    bit exp_vld [$];
    logic [15:0] lfsr = 16'hACE1;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fir3_pipe #(
        .DATA_W(DATA_W), .COEF_W(COEF_W),
        .COEF0(C0), .COEF1(C1), .COEF2(C2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    // One clock: compare the result due now, then present the next sample.
    task automatic cycle(input bit v, input int d, input string tag);
        int xg;
        int y;
        @(negedge clk);
        if (exp_val.size() == 2) begin
            int ev;
            bit evd;
            ev  = exp_val.pop_front();
            evd = exp_vld.pop_front();
            check(out_valid == evd, "R2", int'(out_valid), int'(evd));
            check($signed(out_data) == ev, tag, int'($signed(out_data)), ev);
        end else begin
            check(out_valid == 1'b0, "R6", int'(out_valid), 0);
            check(out_data == '0, "R6", int'($signed(out_data)), 0);
        end
        xg = v ? d : 0;
        y  = C0 * xg + C1 * h1 + C2 * h2;
        h2 = h1;
        h1 = xg;
        exp_val.push_back(y);
        exp_vld.push_back(v);
        in_valid = v;
        in_data  = DATA_W'(d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        in_data = 8'sd55;
        h1 = 0; h2 = 0;
        exp_val.delete();
        exp_vld.delete();
        repeat (2) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R6", int'(out_valid), 0);
            check(out_data == '0, "R6", int'($signed(out_data)), 0);
        end
        rst_n = 1'b1;
        in_valid = 1'b0;
    endtask

    function automatic int next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return int'($signed(lfsr[7:0]));
    endfunction

    initial begin
        do_reset();
        // R6: first results after reset see zero history
        cycle(1, 100, "R6");
        cycle(1, -3, "R6");
        cycle(1, 9, "R6");
        // R7: impulse reveals weights in tap order
        repeat (3) cycle(1, 0, "R7");
        cycle(1, 1, "R7");
        repeat (4) cycle(1, 0, "R7");
        // R1: constant step
        repeat (6) cycle(1, 42, "R1");
        // R3: extreme magnitudes
        repeat (4) cycle(1, -128, "R3");
        repeat (4) cycle(1, 127, "R3");
        for (int i = 0; i < 8; i++) cycle(1, (i % 2) ? 127 : -128, "R3");
        // R4: dense pseudo-random stream
        for (int i = 0; i < 60; i++) cycle(1, next_rand(), "R4");
        // R5: gaps of one, two and three cycles, garbage on in_data
        for (int g = 1; g <= 3; g++) begin
            repeat (g) cycle(0, 99, "R5");
            for (int i = 0; i < 5; i++) cycle(1, next_rand(), "R5");
        end
        repeat (5) cycle(0, -100, "R5");
        for (int i = 0; i < 40; i++) cycle((i % 3) != 0, next_rand(), "R5");
        // R6: reset in the middle of a stream
        for (int i = 0; i < 5; i++) cycle(1, next_rand(), "R1");
        do_reset();
        cycle(1, -128, "R6");
        cycle(1, 127, "R6");
        repeat (4) cycle(1, 5, "R6");
        repeat (4) cycle(0, 0, "R1");
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule